// File: doc/BRIEF.md
# Microprogram Sequencer

This block is the next-address engine of a microcoded processor controller. A micro-PC register points into a built-in control store. Each control-store word holds three things: the datapath control bits for the current step, a jump-type code and an absolute target address. Every cycle the sequencer uses the jump type to pick the next micro-PC. The inputs to that choice are the memory busy line, the datapath zero flag and an opcode-to-start-address dispatch table. The control store holds microcode for instruction fetch, register ALU, immediate ALU, load, store, branch-equal, branch-not-equal, jump-and-link and jump-and-link-register. It also holds an illegal-instruction state.

The datapath is outside the block. It takes the control word on `ctrl` and returns `busy` and `zero`. It also presents the 7-bit opcode and the 3-bit function field of the instruction register. The next-address choice is made by jump type rather than by a full next-state field in each word, so the control store stays narrow. The dispatch table folds many opcodes into a few start addresses.

Top module: `useq_top`

## Requirements
- R1: While reset (`rst_n` low) is applied, `upc` is 0 and `trap` is 0.
- R2: A word whose jump type is "step" moves `upc` to `upc`+1 at the next clock edge.
- R3: A word whose jump type is "wait" keeps `upc` unchanged while `busy` is 1 and moves to `upc`+1 in the cycle `busy` is 0.
- R4: A word whose jump type is "goto" loads its absolute target into `upc`. This type is used to return to address 0 at the end of every instruction.
- R5: A word whose jump type is "dispatch" loads the start address for the opcode. The start addresses are: 0110011 to 3, 0010011 to 6, 0000011 to 9, 0100011 to 14, 1100011 with `funct3`=000 to 19, 1100011 with `funct3`=001 to 25, 1101111 to 29, and 1100111 to 34.
- R6: "Jump-if-zero" goes to the target when `zero` is 1 and to `upc`+1 otherwise. "Jump-if-nonzero" goes to `upc`+1 when `zero` is 1 and to the target otherwise.
- R7: Fetch runs through addresses 0, 1 and 2. Address 1 waits on `busy` and asserts `ctrl[9]` (load instruction register) and `ctrl[3]` (memory drives bus). Address 2 dispatches.
- R8: Register ALU runs 3, 4, 5 and then 0. Immediate ALU runs 6, 7, 8 and then 0.
- R9: Load runs 9 through 13 and waits on `busy` at 12. Store runs 14 through 18 and waits on `busy` at 17. Both then return to 0.
- R10: Branch-equal runs 19, 20, 21. At 21 it returns to 0 if `zero` is 0. Otherwise it continues 22, 23, 24 and then 0.
- R11: Branch-not-equal runs 25, 26, 27. At 27 it returns to 0 if `zero` is 1. Otherwise it goes 28, 22, 23, 24 and then 0.
- R12: Jump-and-link runs 29 to 33 and jump-and-link-register runs 34 to 37, then both go to 0. At 30 and at 35 the link register x1 is written: `ctrl[5]`=1 and `ctrl[12:10]`=4.
- R13: Any other opcode, or opcode 1100011 with any other `funct3`, dispatches to 38. At 38 `trap` is 1 and `ctrl[18]` is 1, and `upc` stays at 38 whatever `busy`, `zero`, `opcode` and `funct3` do, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 7 | Opcode field of the instruction register |
| funct3 | input | 3 | Function field used to tell the branch kinds apart |
| busy | input | 1 | Memory access still in progress |
| zero | input | 1 | Datapath comparison flag |
| upc | output | 6 | Current micro-PC |
| ctrl | output | 19 | Datapath control word of the current step |
| trap | output | 1 | Illegal-instruction trap, held while halted |

## Verification
The assertions take `busy`, `zero`, `opcode` and `funct3` as settled for the whole cycle before each rising edge. The jump choice is a function of their values at that edge. The stimulus meets this by changing every input one time unit after a rising edge. It also holds `opcode` steady from fetch until the dispatch step. The assertions also take it that reset is only applied between instructions or during the halt. The bench applies reset only at those points.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int UPC_W = 6;
    localparam int OPC_W = 7;
    localparam int FN3_W = 3;

    typedef logic [UPC_W-1:0] upc_t;

    typedef enum logic [2:0] {
        JT_NEXT, JT_SPIN, JT_FETCH, JT_DISP, JT_FTRUE, JT_FFALSE
    } jump_e;

    typedef enum logic [2:0] {
        SEL_RS1, SEL_RS2, SEL_RD, SEL_PC, SEL_LINK
    } rsel_e;

    typedef enum logic [2:0] {
        ALU_COPY_A, ALU_COPY_B, ALU_ADD, ALU_SUB,
        ALU_INC4, ALU_DEC4, ALU_FUNC, ALU_JTARG
    } alu_e;

    typedef enum logic [1:0] {
        IMM_I, IMM_S, IMM_B, IMM_J
    } imm_e;

    typedef struct packed {
        logic  trap;
        alu_e  alu_op;
        imm_e  imm_sel;
        rsel_e reg_sel;
        logic  ld_ir;
        logic  ld_ma;
        logic  ld_a;
        logic  ld_b;
        logic  reg_wr;
        logic  en_reg;
        logic  en_mem;
        logic  mem_wr;
        logic  en_alu;
        logic  en_imm;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        ctrl_t ctrl;
        jump_e jt;
        upc_t  tgt;
    } uword_t;

    // microprogram layout
    localparam upc_t A_FETCH0 = upc_t'(0);
    localparam upc_t A_FETCH1 = upc_t'(1);
    localparam upc_t A_FETCH2 = upc_t'(2);
    localparam upc_t A_ALU0   = upc_t'(3);
    localparam upc_t A_ALU1   = upc_t'(4);
    localparam upc_t A_ALU2   = upc_t'(5);
    localparam upc_t A_ALUI0  = upc_t'(6);
    localparam upc_t A_ALUI1  = upc_t'(7);
    localparam upc_t A_ALUI2  = upc_t'(8);
    localparam upc_t A_LD0    = upc_t'(9);
    localparam upc_t A_LD1    = upc_t'(10);
    localparam upc_t A_LD2    = upc_t'(11);
    localparam upc_t A_LD3    = upc_t'(12);
    localparam upc_t A_LD4    = upc_t'(13);
    localparam upc_t A_ST0    = upc_t'(14);
    localparam upc_t A_ST1    = upc_t'(15);
    localparam upc_t A_ST2    = upc_t'(16);
    localparam upc_t A_ST3    = upc_t'(17);
    localparam upc_t A_ST4    = upc_t'(18);
    localparam upc_t A_BEQ0   = upc_t'(19);
    localparam upc_t A_BEQ1   = upc_t'(20);
    localparam upc_t A_BEQ2   = upc_t'(21);
    localparam upc_t A_TK0    = upc_t'(22);
    localparam upc_t A_TK1    = upc_t'(23);
    localparam upc_t A_TK2    = upc_t'(24);
    localparam upc_t A_BNE0   = upc_t'(25);
    localparam upc_t A_BNE1   = upc_t'(26);
    localparam upc_t A_BNE2   = upc_t'(27);
    localparam upc_t A_BNE3   = upc_t'(28);
    localparam upc_t A_JAL0   = upc_t'(29);
    localparam upc_t A_JAL1   = upc_t'(30);
    localparam upc_t A_JAL2   = upc_t'(31);
    localparam upc_t A_JAL3   = upc_t'(32);
    localparam upc_t A_JAL4   = upc_t'(33);
    localparam upc_t A_JALR0  = upc_t'(34);
    localparam upc_t A_JALR1  = upc_t'(35);
    localparam upc_t A_JALR2  = upc_t'(36);
    localparam upc_t A_JALR3  = upc_t'(37);
    localparam upc_t A_ILL    = upc_t'(38);

    localparam logic [OPC_W-1:0] OP_REG    = 7'b0110011;
    localparam logic [OPC_W-1:0] OP_IMM    = 7'b0010011;
    localparam logic [OPC_W-1:0] OP_LOAD   = 7'b0000011;
    localparam logic [OPC_W-1:0] OP_STORE  = 7'b0100011;
    localparam logic [OPC_W-1:0] OP_BRANCH = 7'b1100011;
    localparam logic [OPC_W-1:0] OP_JAL    = 7'b1101111;
    localparam logic [OPC_W-1:0] OP_JALR   = 7'b1100111;

    localparam logic [FN3_W-1:0] FN_EQ = 3'b000;
    localparam logic [FN3_W-1:0] FN_NE = 3'b001;

endpackage

// File: rtl/useq_rom.sv
module useq_rom
    import useq_pkg::*;
(
    input  upc_t   addr,
    output uword_t word
);

    uword_t w;

    always_comb begin
        w     = '0;
        w.jt  = JT_NEXT;
        w.tgt = A_FETCH0;
        unique case (addr)
            A_FETCH0: begin
                w.ctrl.reg_sel = SEL_PC; w.ctrl.en_reg = 1'b1;
                w.ctrl.ld_ma = 1'b1; w.ctrl.ld_a = 1'b1;
            end
            A_FETCH1: begin
                w.ctrl.en_mem = 1'b1; w.ctrl.ld_ir = 1'b1; w.jt = JT_SPIN;
            end
            A_FETCH2: begin
                w.ctrl.alu_op = ALU_INC4; w.ctrl.en_alu = 1'b1;
                w.ctrl.reg_sel = SEL_PC; w.ctrl.reg_wr = 1'b1; w.jt = JT_DISP;
            end
            A_ALU0, A_ALUI0, A_LD0, A_ST0, A_BEQ0, A_BNE0: begin
                w.ctrl.reg_sel = SEL_RS1; w.ctrl.en_reg = 1'b1; w.ctrl.ld_a = 1'b1;
            end
            A_ALU1, A_BEQ1, A_BNE1: begin
                w.ctrl.reg_sel = SEL_RS2; w.ctrl.en_reg = 1'b1; w.ctrl.ld_b = 1'b1;
            end
            A_ALU2, A_ALUI2: begin
                w.ctrl.alu_op = ALU_FUNC; w.ctrl.en_alu = 1'b1;
                w.ctrl.reg_sel = SEL_RD; w.ctrl.reg_wr = 1'b1; w.jt = JT_FETCH;
            end
            A_ALUI1, A_LD1: begin
                w.ctrl.en_imm = 1'b1; w.ctrl.imm_sel = IMM_I; w.ctrl.ld_b = 1'b1;
            end
            A_LD2, A_ST2: begin
                w.ctrl.alu_op = ALU_ADD; w.ctrl.en_alu = 1'b1; w.ctrl.ld_ma = 1'b1;
            end
            A_LD3: begin
                w.ctrl.en_mem = 1'b1; w.ctrl.reg_sel = SEL_RD;
                w.ctrl.reg_wr = 1'b1; w.jt = JT_SPIN;
            end
            A_LD4, A_ST4, A_BNE3: begin
                w.jt  = JT_FETCH;
                w.tgt = (addr == A_BNE3) ? A_TK0 : A_FETCH0;
            end
            A_ST1: begin
                w.ctrl.en_imm = 1'b1; w.ctrl.imm_sel = IMM_S; w.ctrl.ld_b = 1'b1;
            end
            A_ST3: begin
                w.ctrl.reg_sel = SEL_RS2; w.ctrl.en_reg = 1'b1;
                w.ctrl.mem_wr = 1'b1; w.jt = JT_SPIN;
            end
            A_BEQ2, A_BNE2: begin
                w.ctrl.reg_sel = SEL_PC; w.ctrl.en_reg = 1'b1; w.ctrl.ld_a = 1'b1;
                w.jt = (addr == A_BEQ2) ? JT_FFALSE : JT_FTRUE;
            end
            A_TK0, A_JAL2: begin
                w.ctrl.alu_op = ALU_DEC4; w.ctrl.en_alu = 1'b1; w.ctrl.ld_a = 1'b1;
            end
            A_TK1: begin
                w.ctrl.en_imm = 1'b1; w.ctrl.imm_sel = IMM_B; w.ctrl.ld_b = 1'b1;
            end
            A_TK2: begin
                w.ctrl.alu_op = ALU_ADD; w.ctrl.en_alu = 1'b1;
                w.ctrl.reg_sel = SEL_PC; w.ctrl.reg_wr = 1'b1; w.jt = JT_FETCH;
            end
            A_JAL0, A_JALR0: begin
                w.ctrl.reg_sel = SEL_PC; w.ctrl.en_reg = 1'b1; w.ctrl.ld_a = 1'b1;
            end
            A_JAL1, A_JALR1: begin
                w.ctrl.alu_op = ALU_COPY_A; w.ctrl.en_alu = 1'b1;
                w.ctrl.reg_sel = SEL_LINK; w.ctrl.reg_wr = 1'b1;
            end
            A_JAL3: begin
                w.ctrl.en_imm = 1'b1; w.ctrl.imm_sel = IMM_J; w.ctrl.ld_b = 1'b1;
            end
            A_JAL4: begin
                w.ctrl.alu_op = ALU_JTARG; w.ctrl.en_alu = 1'b1;
                w.ctrl.reg_sel = SEL_PC; w.ctrl.reg_wr = 1'b1; w.jt = JT_FETCH;
            end
            A_JALR2: begin
                w.ctrl.reg_sel = SEL_RS1; w.ctrl.en_reg = 1'b1; w.ctrl.ld_a = 1'b1;
            end
            A_JALR3: begin
                w.ctrl.alu_op = ALU_COPY_A; w.ctrl.en_alu = 1'b1;
                w.ctrl.reg_sel = SEL_PC; w.ctrl.reg_wr = 1'b1; w.jt = JT_FETCH;
            end
            default: begin
                // illegal-instruction halt, also covers unused addresses
                w.ctrl.trap = 1'b1; w.jt = JT_FETCH; w.tgt = A_ILL;
            end
        endcase
    end

    assign word = w;

endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
    import useq_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic [FN3_W-1:0] funct3,
    output upc_t             start
);

    always_comb begin
        start = A_ILL;
        unique case (opcode)
            OP_REG:    start = A_ALU0;
            OP_IMM:    start = A_ALUI0;
            OP_LOAD:   start = A_LD0;
            OP_STORE:  start = A_ST0;
            OP_JAL:    start = A_JAL0;
            OP_JALR:   start = A_JALR0;
            OP_BRANCH: begin
                if (funct3 == FN_EQ)      start = A_BEQ0;
                else if (funct3 == FN_NE) start = A_BNE0;
                else                      start = A_ILL;
            end
            default:   start = A_ILL;
        endcase
    end

endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
(
    input  upc_t  upc,
    input  jump_e jt,
    input  upc_t  tgt,
    input  upc_t  disp,
    input  logic  busy,
    input  logic  zero,
    output upc_t  nxt
);

    upc_t inc;
    assign inc = upc + upc_t'(1);

    always_comb begin
        unique case (jt)
            JT_NEXT:   nxt = inc;
            JT_SPIN:   nxt = busy ? upc : inc;
            JT_FETCH:  nxt = tgt;
            JT_DISP:   nxt = disp;
            JT_FTRUE:  nxt = zero ? tgt : inc;
            JT_FFALSE: nxt = zero ? inc : tgt;
            default:   nxt = A_ILL;
        endcase
    end

endmodule

// File: rtl/useq_top.sv
module useq_top
    import useq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [FN3_W-1:0]  funct3,
    input  logic              busy,
    input  logic              zero,
    output logic [UPC_W-1:0]  upc,
    output logic [CTRL_W-1:0] ctrl,
    output logic              trap
);

    typedef struct packed {
        upc_t upc;
    } seq_state_t;

    seq_state_t st_d, st_q;
    uword_t     cur_w;
    jump_e      cur_jt;
    upc_t       cur_tgt;
    upc_t       disp_start;
    upc_t       nxt_upc;

    useq_rom u_rom (
        .addr (st_q.upc),
        .word (cur_w)
    );

    useq_dispatch u_disp (
        .opcode (opcode),
        .funct3 (funct3),
        .start  (disp_start)
    );

    assign cur_jt  = cur_w.jt;
    assign cur_tgt = cur_w.tgt;

    useq_next u_next (
        .upc  (st_q.upc),
        .jt   (cur_jt),
        .tgt  (cur_tgt),
        .disp (disp_start),
        .busy (busy),
        .zero (zero),
        .nxt  (nxt_upc)
    );

    always_comb begin
        st_d     = st_q;
        st_d.upc = nxt_upc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{upc: A_FETCH0};
        else        st_q <= st_d;
    end

    assign upc  = st_q.upc;
    assign ctrl = cur_w.ctrl;
    assign trap = cur_w.ctrl.trap;

endmodule

// File: rtl/useq_chk.sv
module useq_chk
    import useq_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  busy,
    input logic  zero,
    input upc_t  upc,
    input logic  trap,
    input jump_e jt,
    input upc_t  tgt,
    input upc_t  disp
);

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (jt == JT_NEXT) |=> (upc == upc_t'($past(upc) + 1)));

    assert_wait_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (jt == JT_SPIN && busy) |=> $stable(upc));

    assert_wait_go_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (jt == JT_SPIN && !busy) |=> (upc == upc_t'($past(upc) + 1)));

    assert_goto_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (jt == JT_FETCH) |=> (upc == $past(tgt)));

    assert_dispatch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (jt == JT_DISP) |=> (upc == $past(disp)));

    assert_jz_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (jt == JT_FTRUE) |=>
        (upc == ($past(zero) ? $past(tgt) : upc_t'($past(upc) + 1))));

    assert_jnz_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (jt == JT_FFALSE) |=>
        (upc == ($past(zero) ? upc_t'($past(upc) + 1) : $past(tgt))));

    assert_halt_R13: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> (trap && $stable(upc)));

endmodule

bind useq_top useq_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (busy),
    .zero  (zero),
    .upc   (upc),
    .trap  (trap),
    .jt    (cur_jt),
    .tgt   (cur_tgt),
    .disp  (disp_start)
);

// File: tb/useq_top_test.sv
module useq_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  opcode = 7'b0;
    logic [2:0]  funct3 = 3'b0;
    logic        busy = 1'b0;
    logic        zero = 1'b0;
    logic [5:0]  upc;
    logic [18:0] ctrl;
    logic        trap;

    int n_run  = 0;
    int n_fail = 0;

    useq_top uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .opcode (opcode),
        .funct3 (funct3),
        .busy   (busy),
        .zero   (zero),
        .upc    (upc),
        .ctrl   (ctrl),
        .trap   (trap)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        busy = 1'b0; zero = 1'b0;
        #1 rst_n = 1'b0;
        tick(); tick();
        check("R1 upc in reset", int'(upc), 0);
        check("R1 trap in reset", int'(trap), 0);
        rst_n = 1'b1;
    endtask

    // fetch with a busy wait, then dispatch; ends on the start address
    task automatic fetch(input logic [6:0] op, input logic [2:0] f3, input int start);
        opcode = op; funct3 = f3; busy = 1'b1;
        check("R7 fetch0", int'(upc), 0);
        tick(); check("R7 fetch1", int'(upc), 1);
        check("R7 ld_ir", int'(ctrl[9]), 1);
        check("R7 en_mem", int'(ctrl[3]), 1);
        tick(); check("R3 wait holds", int'(upc), 1);
        busy = 1'b0;
        tick(); check("R3 wait releases", int'(upc), 2);
        tick(); check("R5 dispatch", int'(upc), start);
    endtask

    task automatic walk(input string req, input int from, input int to);
        for (int a = from; a <= to; a++) begin
            tick(); check(req, int'(upc), a);
        end
    endtask

    task automatic test_alu();
        fetch(7'b0110011, 3'b000, 3);
        walk("R8 reg alu R2", 4, 5);
        tick(); check("R8 reg alu return R4", int'(upc), 0);
        fetch(7'b0010011, 3'b101, 6);
        walk("R8 imm alu", 7, 8);
        tick(); check("R8 imm alu return", int'(upc), 0);
    endtask

    task automatic test_mem();
        fetch(7'b0000011, 3'b010, 9);
        walk("R9 load", 10, 11);
        busy = 1'b1;
        tick(); check("R9 load wait entry", int'(upc), 12);
        tick(); check("R9 load wait hold", int'(upc), 12);
        busy = 1'b0;
        tick(); check("R9 load go", int'(upc), 13);
        tick(); check("R9 load return", int'(upc), 0);
        fetch(7'b0100011, 3'b010, 14);
        walk("R9 store", 15, 16);
        busy = 1'b1;
        tick(); check("R9 store wait entry", int'(upc), 17);
        tick(); tick(); check("R9 store wait hold", int'(upc), 17);
        busy = 1'b0;
        tick(); check("R9 store go", int'(upc), 18);
        tick(); check("R9 store return", int'(upc), 0);
    endtask

    task automatic test_branch();
        fetch(7'b1100011, 3'b000, 19);
        tick(); check("R10 beq", int'(upc), 20);
        zero = 1'b0;
        tick(); check("R10 beq test", int'(upc), 21);
        tick(); check("R10 beq not taken R6", int'(upc), 0);
        fetch(7'b1100011, 3'b000, 19);
        walk("R10 beq", 20, 21);
        zero = 1'b1;
        walk("R10 beq taken R6", 22, 24);
        zero = 1'b0;
        tick(); check("R10 beq return", int'(upc), 0);
        fetch(7'b1100011, 3'b001, 25);
        walk("R11 bne", 26, 27);
        zero = 1'b1;
        tick(); check("R11 bne not taken R6", int'(upc), 0);
        zero = 1'b0;
        fetch(7'b1100011, 3'b001, 25);
        walk("R11 bne", 26, 28);
        tick(); check("R11 bne join", int'(upc), 22);
        walk("R11 bne taken", 23, 24);
        tick(); check("R11 bne return", int'(upc), 0);
    endtask

    task automatic test_jumps();
        fetch(7'b1101111, 3'b000, 29);
        tick(); check("R12 jal", int'(upc), 30);
        check("R12 jal link write", int'(ctrl[5]), 1);
        check("R12 jal link select", int'(ctrl[12:10]), 4);
        walk("R12 jal", 31, 33);
        tick(); check("R12 jal return", int'(upc), 0);
        fetch(7'b1100111, 3'b000, 34);
        tick(); check("R12 jalr", int'(upc), 35);
        check("R12 jalr link write", int'(ctrl[5]), 1);
        check("R12 jalr link select", int'(ctrl[12:10]), 4);
        walk("R12 jalr", 36, 37);
        tick(); check("R12 jalr return", int'(upc), 0);
    endtask

    task automatic test_illegal(input logic [6:0] op, input logic [2:0] f3);
        fetch(op, f3, 38);
        check("R13 trap", int'(trap), 1);
        check("R13 trap ctrl bit", int'(ctrl[18]), 1);
        busy = 1'b1; zero = 1'b1; opcode = 7'b0110011; funct3 = 3'b000;
        tick(); check("R13 halt", int'(upc), 38);
        busy = 1'b0; zero = 1'b0;
        tick(); tick(); check("R13 halt held", int'(upc), 38);
        check("R13 trap held", int'(trap), 1);
        do_reset();
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected 0 cycles left", 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        test_alu();
        test_mem();
        test_branch();
        test_jumps();
        test_illegal(7'b0000000, 3'b000);
        test_illegal(7'b1100011, 3'b010);
        test_illegal(7'b0110111, 3'b000);
        test_alu();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule